// File: doc/BRIEF.md
# Set-Clear Interrupt Collector

This block gathers five interrupt events into one byte-wide register. Four events come from nearby logic as single-cycle pulses: two timer underflows, a time-of-day alarm and a serial shift register going full or empty. The fifth comes from an external active-low pin, where each falling edge counts as an event. Events are latched as pending flags whether or not they are enabled. A five-bit enable mask decides which pending flags pull the active-low interrupt line.

Software changes the mask through a single write port. Bit 7 of the written byte chooses the action: when it is 1, every mask bit whose data bit is 1 is set, and when it is 0, those same mask bits are cleared. Mask bits whose data bits are 0 keep their value. The read port always shows the pending flags and a summary bit. A read strobe clears all flags at the next clock edge, but an event that arrives in the same cycle as the read is kept for the following read.

Top module: `evt_irq_ctrl`

## Requirements
- R1: After reset, the mask is all zero, no flag is pending, `rdata_o` reads 0x00 and `irq_n_o` is 1.
- R2: A write with `wdata_i[7]`=1 sets each mask bit `k` (k = 0..4) for which `wdata_i[k]`=1. The new mask takes effect after the clock edge that samples the write.
- R3: A write with `wdata_i[7]`=0 clears each mask bit `k` for which `wdata_i[k]`=1. Mask bits whose data bits are 0 keep their value, and data bits 6:5 are ignored.
- R4: A pulse on `src_i[k]` (bit 0 timer A, bit 1 timer B, bit 2 alarm, bit 3 serial) sets pending flag `k`, which reads at `rdata_o[k]` after that edge. This happens regardless of the mask.
- R5: `rdata_o[7]` is 1 exactly when some pending flag also has its mask bit set. `rdata_o[6:5]` always read 0.
- R6: A cycle with `rd_i`=1 clears every pending flag at the next edge, unless an event arrives in that same cycle.
- R7: An event that arrives in the same cycle as a read is set after the clearing edge, so the next read shows it.
- R8: A falling edge on `flag_pin_n_i` sets pending flag 4 at the third rising clock edge after the pin falls. The pin goes through two synchronizer flops and one edge flop. A rising edge on the pin sets no flag.
- R9: `irq_n_o` is 0 exactly while some pending flag has its mask bit set, and 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_i | input | 1 | Mask write strobe |
| wdata_i | input | 8 | Write data: bit 7 chooses set or clear, bits 4:0 select mask bits |
| rd_i | input | 1 | Read strobe: clears the pending flags at the next edge |
| rdata_o | output | 8 | Bit 7 is the summary bit, bits 6:5 read 0, bits 4:0 are the pending flags |
| src_i | input | 4 | Single-cycle event pulses: timer A, timer B, alarm, serial |
| flag_pin_n_i | input | 1 | External pin; a falling edge is an event |
| irq_n_o | output | 1 | Active-low interrupt request |

## Verification
Two actions can land in the same cycle: a read that clears the pending flags, and a new event that sets one. The bench provokes this collision in two ways. It issues directed reads together with timer and serial pulses, and it times a pin fall so that its detected edge meets a read strobe. It also drives random traffic with frequent reads and pulses. In every case the bench's own model decides the outcome: a coincident event must show up in the next readout while all older flags are gone. A simultaneous mask write alongside a read is covered the same way, by checking both the summary bit and the interrupt line.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
  localparam int NSRC      = 5;
  localparam int NPULSE    = NSRC - 1;
  localparam int DW        = 8;
  localparam int SETCLR_B  = 7;
  localparam int SUMMARY_B = 7;

  typedef logic [NSRC-1:0] evt_vec_t;

  function automatic evt_vec_t mask_apply(evt_vec_t cur, logic [DW-1:0] wd);
    if (wd[SETCLR_B]) return cur | wd[NSRC-1:0];
    else              return cur & ~wd[NSRC-1:0];
  endfunction

  function automatic logic any_armed(evt_vec_t pend, evt_vec_t msk);
    return |(pend & msk);
  endfunction

  function automatic evt_vec_t pend_next(evt_vec_t pend, logic clr, evt_vec_t evt);
    return (clr ? '0 : pend) | evt;
  endfunction
endpackage

// File: rtl/evt_pin_fall.sv
module evt_pin_fall (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n_i,
  output logic fall_o
);
  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      last_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_n_i};
      last_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign fall_o = last_q & ~sync_q[SYNC_STAGES-1];

  AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |=> !fall_o); // R8
endmodule

// File: rtl/evt_mask_reg.sv
module evt_mask_reg
  import evt_irq_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  output evt_vec_t      mask_o
);
  evt_vec_t mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    mask_q <= '0;
    else if (wr_i) mask_q <= mask_apply(mask_q, wdata_i);
  end

  assign mask_o = mask_q;

  AST_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && wdata_i[SETCLR_B]) |=> ((mask_q & $past(wdata_i[NSRC-1:0])) == $past(wdata_i[NSRC-1:0]))); // R2
  AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !wdata_i[SETCLR_B]) |=> ((mask_q & $past(wdata_i[NSRC-1:0])) == '0)); // R3
  AST_UNSELECTED_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> (((mask_q ^ $past(mask_q)) & ~$past(wdata_i[NSRC-1:0])) == '0)); // R3
  AST_NO_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> $stable(mask_q)); // R2
endmodule

// File: rtl/evt_pend_reg.sv
module evt_pend_reg
  import evt_irq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     rd_i,
  input  evt_vec_t evt_i,
  output evt_vec_t pend_o
);
  evt_vec_t pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_next(pend_q, rd_i, evt_i);
  end

  assign pend_o = pend_q;

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && evt_i == '0) |=> (pend_q == '0)); // R6
  AST_EVENT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i != '0) |=> ((pend_q & $past(evt_i)) == $past(evt_i))); // R7
  AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_i && evt_i == '0) |=> $stable(pend_q)); // R4
endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
  import evt_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic              rd_i,
  output logic [DW-1:0]     rdata_o,
  input  logic [NPULSE-1:0] src_i,
  input  logic              flag_pin_n_i,
  output logic              irq_n_o
);
  localparam int PAD_W = SUMMARY_B - NSRC;

  logic     pin_fall;
  evt_vec_t evt_all;
  evt_vec_t mask;
  evt_vec_t pend;
  logic     armed;

  evt_pin_fall u_pin (
    .clk     (clk),
    .rst_n   (rst_n),
    .pin_n_i (flag_pin_n_i),
    .fall_o  (pin_fall)
  );

  assign evt_all = {pin_fall, src_i};

  evt_mask_reg u_mask (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (wr_i),
    .wdata_i (wdata_i),
    .mask_o  (mask)
  );

  evt_pend_reg u_pend (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_i   (rd_i),
    .evt_i  (evt_all),
    .pend_o (pend)
  );

  assign armed   = any_armed(pend, mask);
  assign rdata_o = {armed, {PAD_W{1'b0}}, pend};
  assign irq_n_o = ~armed;

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n_o |-> (pend != '0)); // R9
  AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_o[SUMMARY_B-1:NSRC] == '0); // R5
  AST_PIN_TO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    pin_fall |=> pend[NSRC-1]); // R8
endmodule

// File: tb/evt_irq_ctrl_tb.sv
module evt_irq_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_i = 1'b0;
  logic [7:0] wdata_i = 8'h00;
  logic       rd_i = 1'b0;
  logic [7:0] rdata_o;
  logic [3:0] src_i = 4'h0;
  logic       flag_pin_n_i = 1'b1;
  logic       irq_n_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [4:0] m_mask = '0;
  logic [4:0] m_pend = '0;
  logic [2:0] m_pin  = 3'b111;

  always #10 clk = ~clk;

  evt_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .wr_i(wr_i), .wdata_i(wdata_i), .rd_i(rd_i),
    .rdata_o(rdata_o), .src_i(src_i), .flag_pin_n_i(flag_pin_n_i), .irq_n_o(irq_n_o)
  );

  function automatic logic [7:0] exp_read(logic [4:0] p, logic [4:0] m);
    logic hit = 1'b0;
    for (int k = 0; k < 5; k++) if (p[k] && m[k]) hit = 1'b1;
    return {hit, 2'b00, p};
  endfunction

  function automatic logic [4:0] exp_mask(logic [4:0] m, logic [7:0] d);
    logic [4:0] r = m;
    for (int k = 0; k < 5; k++) if (d[k]) r[k] = d[7];
    return r;
  endfunction

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic step(input logic wr, input logic [7:0] wd, input logic rd,
                      input logic [3:0] src, input logic pin, input string tag);
    logic [4:0] evt;
    logic [7:0] e;
    @(negedge clk);
    wr_i = wr; wdata_i = wd; rd_i = rd; src_i = src; flag_pin_n_i = pin;
    evt = {m_pin[2] & ~m_pin[1], src};
    @(posedge clk);
    m_pend = (rd ? 5'b0 : m_pend) | evt;
    if (wr) m_mask = exp_mask(m_mask, wd);
    m_pin  = {m_pin[1:0], pin};
    #2;
    e = exp_read(m_pend, m_mask);
    chk(rdata_o, e, tag);
    chk({7'b0, irq_n_o}, {7'b0, ~e[7]}, {tag, " R9"});
  endtask

  task automatic look(input logic [7:0] exp, input string tag);
    #3;
    chk(rdata_o, exp, tag);
    chk({7'b0, irq_n_o}, {7'b0, ~exp[7]}, {tag, " R9"});
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    #2;
    look(8'h00, "R1 reset");
    @(negedge clk); rst_n = 1'b1;

    step(0, 8'h00, 0, 4'h1, 1, "R4");
    look(8'h01, "R4 unmasked latch");
    step(1, 8'h81, 0, 4'h0, 1, "R2");
    look(8'h81, "R2 set mask");
    step(1, 8'hE0, 0, 4'h0, 1, "R3");
    look(8'h81, "R3 bits 6:5 ignored");
    step(1, 8'h01, 0, 4'h0, 1, "R3");
    look(8'h01, "R3 clear mask");
    step(1, 8'h9E, 0, 4'h0, 1, "R2");
    look(8'h01, "R5 no armed flag");
    step(0, 8'h00, 1, 4'h2, 1, "R7");
    look(8'h82, "R7 coincident kept");
    step(0, 8'h00, 1, 4'h0, 1, "R6");
    look(8'h00, "R6 read clears");
    step(0, 8'h00, 0, 4'h8, 1, "R4");
    look(8'h88, "R4 serial");
    step(1, 8'h08, 1, 4'h0, 1, "R6");
    look(8'h00, "R6 read with write");

    step(0, 8'h00, 0, 4'h0, 0, "R8");
    look(8'h00, "R8 sync stage 1");
    step(0, 8'h00, 0, 4'h0, 0, "R8");
    look(8'h00, "R8 sync stage 2");
    step(0, 8'h00, 0, 4'h0, 0, "R8");
    look(8'h90, "R8 pin fall");
    step(0, 8'h00, 1, 4'h0, 1, "R6");
    look(8'h00, "R6 clear pin flag");
    repeat (4) step(0, 8'h00, 0, 4'h0, 1, "R8");
    look(8'h00, "R8 rising ignored");
    step(0, 8'h00, 0, 4'h0, 0, "R8");
    step(0, 8'h00, 0, 4'h0, 0, "R8");
    step(0, 8'h00, 1, 4'h0, 0, "R7");
    look(8'h90, "R7 pin edge with read");

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[0] & r[1], r[15:8], r[2] & r[3], r[7:4] & r[19:16] & r[23:20],
           (r[27:24] == 4'h0) ? ~flag_pin_n_i : flag_pin_n_i, "R5 R7 random");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule